// File: doc/BRIEF.md
# Divider-Driven Interval Timer

This block keeps a free-running 16-bit divider that counts system clocks in steps of four, one step per machine cycle, and derives two things from it. The first is a programmable 8-bit interval counter. It advances when the logical AND of its enable bit and one selected divider bit falls from 1 to 0. When it wraps it raises a one-cycle interrupt request. The second is a tick for an external audio frame sequencer. That tick comes from the falling edge of a high divider bit, and which bit is used depends on whether the system runs in double speed.

Software reaches four byte-wide registers through a small port. A separate write strobe and read address are provided. Reads are combinational. The registers are:

- the divider's upper byte
- the interval counter
- the reload value
- a control byte

Because the counter is clocked by an edge detector and not by a prescaler terminal count, three writes can each cause an immediate extra count: clearing the divider, disabling the counter, or moving the watched bit. An overflow does not reload at once. The counter sits at zero for one machine cycle first, and only then is the reload value copied in.

Top module: `ivt_timer`

## Requirements
- R1: The divider holds its value when `mcyc_en` is low. It adds 4 (modulo 2^16) on each clock with `mcyc_en` high. Reading address 0 returns divider bits 15:8.
- R2: A write to address 0 clears the whole divider to zero, whatever the data byte.
- R3: Control bit 2 enables counting. Control bits 1:0 pick the count period: code 0 is 1024 clocks (256 machine cycles), code 1 is 16 (4), code 2 is 64 (16) and code 3 is 256 (64).
- R4: The counter (address 1) increments when the enable AND the watched divider bit falls from 1 to 0. The watched bit is 9, 3, 5 or 7 for codes 0, 1, 2 and 3.
- R5: A divider clear or a control write that makes that combined signal fall increments the counter on the same clock edge as the write.
- R6: An increment from 0xFF leaves the counter at 0x00 until the next `mcyc_en` clock, on whose edge the reload value (address 2) is copied in.
- R7: `timer_irq` is high for exactly one clock: the `mcyc_en` clock whose edge copies the reload value.
- R8: A reload-value write on that same reload clock makes the newly written value the one loaded into the counter.
- R9: A counter write while it sits at zero awaiting reload cancels the reload and the interrupt. The counter takes the written value.
- R10: After a reload, counter writes are ignored until the next `mcyc_en` clock edge.
- R11: `seq_tick` pulses when divider bit 12 falls with `dbl_speed` low, or when bit 13 falls with `dbl_speed` high.
- R12: A divider clear while the tick's selected bit is 1 also pulses `seq_tick` on that write clock.
- R13: Addresses are 0 divider, 1 counter, 2 reload value, 3 control. Control reads return bits 7:3 as 1. After reset the divider, counter, reload value and control are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcyc_en | input | 1 | Machine-cycle enable; the divider steps on clocks where it is high |
| dbl_speed | input | 1 | Selects divider bit 13 instead of 12 for the sequencer tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| timer_irq | output | 1 | One-clock interrupt request on counter reload |
| seq_tick | output | 1 | One-clock frame-sequencer tick |

## Verification
Two pairs of functions can land in the same clock. The first pair is the delayed reload and a software write of the reload value. The bench drives the counter to overflow and then, in the single machine-cycle clock that performs the reload, also writes a new reload value. It passes only if the interrupt fires in that clock and the counter shows the new value. The second pair is a divider clear and the edge detectors. The bench places the watched bit or the tick bit at 1 and issues the clear. It expects an extra count or a sequencer tick on the write clock itself, and no effect when that bit was 0.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   localparam logic [1:0] ADR_DIV  = 2'd0;
   localparam logic [1:0] ADR_CNT  = 2'd1;
   localparam logic [1:0] ADR_MOD  = 2'd2;
   localparam logic [1:0] ADR_CTL  = 2'd3;

   typedef enum logic [1:0] {
      RLD_RUN  = 2'd0,
      RLD_PEND = 2'd1,
      RLD_DONE = 2'd2
   } rld_state_e;

   // divider bit watched for each period code (half the period)
   function automatic int unsigned tap_for(input logic [1:0] code);
      case (code)
         2'd0:    return 9;
         2'd1:    return 3;
         2'd2:    return 5;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/ivt_divider.sv
module ivt_divider #(
   parameter int DIV_W    = 16,
   parameter int STEP     = 4,
   parameter int FS_TAP_N = 12,
   parameter int FS_TAP_D = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             clr,
   input  logic             dbl,
   output logic [DIV_W-1:0] div_q,
   output logic [DIV_W-1:0] div_d,
   output logic             fs_tick
);

   localparam logic [DIV_W-1:0] STEP_V = DIV_W'(STEP);

   generate
      if (DIV_W < 10) begin : g_bad_width
         $error("ivt_divider: DIV_W must cover the widest timer tap");
      end
      if ((STEP < 1) || ((STEP & (STEP - 1)) != 0)) begin : g_bad_step
         $error("ivt_divider: STEP must be a power of two");
      end
      if ((FS_TAP_N >= DIV_W) || (FS_TAP_D >= DIV_W)) begin : g_bad_tap
         $error("ivt_divider: sequencer taps exceed divider width");
      end
   endgenerate

   logic fs_old, fs_new;

   always_comb begin
      if (clr)          div_d = '0;
      else if (step_en) div_d = div_q + STEP_V;
      else              div_d = div_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_d;
   end

   assign fs_old  = dbl ? div_q[FS_TAP_D] : div_q[FS_TAP_N];
   assign fs_new  = dbl ? div_d[FS_TAP_D] : div_d[FS_TAP_N];
   assign fs_tick = fs_old & ~fs_new;

   // R1
   div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !clr) |=> (div_q == DIV_W'($past(div_q) + STEP_V)));

   // R2
   div_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (div_q == '0));

   // R11
   fs_tick_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_tick && !dbl) |=> !div_q[FS_TAP_N]);

   // R11
   fs_tick_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_tick && dbl) |=> !div_q[FS_TAP_D]);

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
   import ivt_pkg::*;
#(
   parameter int DIV_W = 16,
   parameter int DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [DIV_W-1:0] div_q,
   input  logic [DIV_W-1:0] div_d,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    cnt_q,
   output logic [DW-1:0]    mod_q,
   output logic [2:0]       ctl_q,
   output logic             irq
);

   localparam int IW = $clog2(DIV_W);

   generate
      if (DW < 3) begin : g_bad_dw
         $error("ivt_counter: data width too small for control field");
      end
   endgenerate

   rld_state_e     st_q, st_d;
   logic [DW-1:0]  cnt_d, reload_val;
   logic [2:0]     ctl_nx;
   logic [IW-1:0]  tap_o, tap_n;
   logic           wr_cnt, wr_mod, wr_ctl;
   logic           sig_o, sig_n, inc;

   assign wr_cnt = wr_en && (wr_addr == ADR_CNT);
   assign wr_mod = wr_en && (wr_addr == ADR_MOD);
   assign wr_ctl = wr_en && (wr_addr == ADR_CTL);

   assign ctl_nx = wr_ctl ? wr_data[2:0] : ctl_q;
   assign tap_o  = IW'(tap_for(ctl_q[1:0]));
   assign tap_n  = IW'(tap_for(ctl_nx[1:0]));

   // falling edge of (enable AND watched bit), judged on present vs next state
   assign sig_o = ctl_q[2]  & div_q[tap_o];
   assign sig_n = ctl_nx[2] & div_d[tap_n];
   assign inc   = sig_o & ~sig_n;

   assign reload_val = wr_mod ? wr_data : mod_q;
   assign irq        = (st_q == RLD_PEND) && step_en && !wr_cnt;

   always_comb begin
      cnt_d = cnt_q;
      st_d  = st_q;
      case (st_q)
         RLD_PEND: begin
            if (wr_cnt) begin
               cnt_d = wr_data;
               st_d  = RLD_RUN;
            end else if (step_en) begin
               cnt_d = reload_val;
               st_d  = RLD_DONE;
            end
         end
         default: begin
            if ((st_q == RLD_DONE) && step_en) st_d = RLD_RUN;
            if (wr_cnt && (st_q == RLD_RUN)) begin
               cnt_d = wr_data;
            end else if (inc) begin
               if (cnt_q == {DW{1'b1}}) begin
                  cnt_d = '0;
                  st_d  = RLD_PEND;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mod_q <= '0;
         ctl_q <= '0;
         st_q  <= RLD_RUN;
      end else begin
         cnt_q <= cnt_d;
         st_q  <= st_d;
         if (wr_mod) mod_q <= wr_data;
         if (wr_ctl) ctl_q <= wr_data[2:0];
      end
   end

   // R6
   irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt_q == '0));

   // R7
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R9
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == RLD_PEND) && wr_cnt) |=> ((cnt_q == $past(wr_data)) && !irq));

   // R10
   reloaded_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == RLD_DONE) && wr_cnt && !inc) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int DIV_W    = 16,
   parameter int DW       = 8,
   parameter int STEP     = 4,
   parameter int FS_TAP_N = 12,
   parameter int FS_TAP_D = 13,
   parameter bit RD_PIPE  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mcyc_en,
   input  logic          dbl_speed,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [1:0]    rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          timer_irq,
   output logic          seq_tick
);

   generate
      if (DIV_W < DW) begin : g_bad_view
         $error("ivt_timer: divider narrower than register view");
      end
   endgenerate

   logic [DIV_W-1:0] div_q, div_d;
   logic [DW-1:0]    cnt_q, mod_q, rd_mux;
   logic [2:0]       ctl_q;
   logic             div_clr;

   assign div_clr = wr_en && (wr_addr == ADR_DIV);

   ivt_divider #(
      .DIV_W(DIV_W), .STEP(STEP), .FS_TAP_N(FS_TAP_N), .FS_TAP_D(FS_TAP_D)
   ) div_i (
      .clk(clk), .rst_n(rst_n), .step_en(mcyc_en), .clr(div_clr),
      .dbl(dbl_speed), .div_q(div_q), .div_d(div_d), .fs_tick(seq_tick)
   );

   ivt_counter #(.DIV_W(DIV_W), .DW(DW)) cnt_i (
      .clk(clk), .rst_n(rst_n), .step_en(mcyc_en),
      .div_q(div_q), .div_d(div_d),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_q(cnt_q), .mod_q(mod_q), .ctl_q(ctl_q), .irq(timer_irq)
   );

   always_comb begin
      case (rd_addr)
         ADR_DIV: rd_mux = div_q[DIV_W-1 -: DW];
         ADR_CNT: rd_mux = cnt_q;
         ADR_MOD: rd_mux = mod_q;
         default: rd_mux = {{(DW-3){1'b1}}, ctl_q};
      endcase
   end

   generate
      if (RD_PIPE) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rd_data = rd_mux;
      end
   endgenerate

   // R13
   ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!RD_PIPE && (rd_addr == ADR_CTL)) |-> (rd_data[DW-1:3] == {(DW-3){1'b1}}));

endmodule

// File: tb/ivt_timer_tb_top.sv
`timescale 1ns/1ps
module ivt_timer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mcyc_en = 1'b0;
   logic       dbl_speed = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       timer_irq;
   logic       seq_tick;

   int n_chk = 0;
   int n_bad = 0;
   int irq_cnt = 0;
   int seq_cnt = 0;
   logic irq_w, seq_w;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ivt_timer dut_i (
      .clk(clk), .rst_n(rst_n), .mcyc_en(mcyc_en), .dbl_speed(dbl_speed),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .timer_irq(timer_irq), .seq_tick(seq_tick)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      #2 irq_w = timer_irq; seq_w = seq_tick;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         mcyc_en = 1'b1;
         #2;
         if (timer_irq) irq_cnt++;
         if (seq_tick)  seq_cnt++;
      end
      @(posedge clk);
      #1 mcyc_en = 1'b0;
   endtask

   task automatic step_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      mcyc_en = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
      #2 irq_w = timer_irq;
      @(posedge clk);
      #1 begin mcyc_en = 1'b0; wr_en = 1'b0; end
   endtask

   task automatic prep(input logic [7:0] ctl, input logic [7:0] modv, input logic [7:0] cnt);
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h00);
      run(2);
      wr(2'd0, 8'h00);
      wr(2'd3, ctl);
      wr(2'd2, modv);
      wr(2'd1, cnt);
      irq_cnt = 0; seq_cnt = 0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(2'd0, v); chk("R13 reset div", v, 8'h00);
      rd(2'd1, v); chk("R13 reset cnt", v, 8'h00);
      rd(2'd2, v); chk("R13 reset mod", v, 8'h00);
      rd(2'd3, v); chk("R13 reset ctl", v, 8'hF8);
      chk("R7 reset irq", int'(timer_irq), 0);
   endtask

   task automatic t_divider();
      logic [7:0] v;
      prep(8'h00, 8'h00, 8'h00);
      run(64);
      rd(2'd0, v); chk("R1 div after 64 steps", v, 8'h01);
      repeat (10) @(negedge clk);
      rd(2'd0, v); chk("R1 div holds without enable", v, 8'h01);
      wr(2'd0, 8'hA5);
      rd(2'd0, v); chk("R2 div clear any data", v, 8'h00);
      run(16384);
      rd(2'd0, v); chk("R1 div wraps", v, 8'h00);
      run(64);
      rd(2'd0, v); chk("R1 div after wrap", v, 8'h01);
   endtask

   task automatic t_periods();
      logic [7:0] v;
      prep(8'h05, 8'h00, 8'h00);
      run(40);
      rd(2'd1, v); chk("R3 R4 code1 count", v, 8'd10);
      prep(8'h06, 8'h00, 8'h00);
      run(32);
      rd(2'd1, v); chk("R3 R4 code2 count", v, 8'd2);
      prep(8'h07, 8'h00, 8'h00);
      run(64);
      rd(2'd1, v); chk("R3 R4 code3 count", v, 8'd1);
      prep(8'h04, 8'h00, 8'h00);
      run(255);
      rd(2'd1, v); chk("R3 R4 code0 before edge", v, 8'd0);
      run(1);
      rd(2'd1, v); chk("R3 R4 code0 at edge", v, 8'd1);
      prep(8'h01, 8'h00, 8'h00);
      run(40);
      rd(2'd1, v); chk("R3 disabled no count", v, 8'd0);
   endtask

   task automatic t_glitch();
      logic [7:0] v;
      prep(8'h05, 8'h00, 8'h00);
      run(2);
      wr(2'd0, 8'h00);
      rd(2'd1, v); chk("R5 div clear with bit set", v, 8'd1);
      run(1);
      wr(2'd0, 8'h00);
      rd(2'd1, v); chk("R5 div clear with bit clear", v, 8'd1);
      prep(8'h05, 8'h00, 8'h00);
      run(2);
      wr(2'd3, 8'h01);
      rd(2'd1, v); chk("R5 disable write counts", v, 8'd1);
      wr(2'd3, 8'h05);
      wr(2'd3, 8'h06);
      rd(2'd1, v); chk("R5 select change counts", v, 8'd2);
   endtask

   task automatic t_overflow();
      logic [7:0] v;
      prep(8'h05, 8'h80, 8'hFE);
      run(4);
      rd(2'd1, v); chk("R4 count to FF", v, 8'hFF);
      run(4);
      rd(2'd1, v); chk("R6 zero window", v, 8'h00);
      chk("R7 no irq before reload", irq_cnt, 0);
      run(1);
      chk("R7 irq on reload clock", irq_cnt, 1);
      rd(2'd1, v); chk("R6 reloaded from mod", v, 8'h80);
      run(3);
      chk("R7 single irq", irq_cnt, 1);
      rd(2'd1, v); chk("R4 count after reload", v, 8'h81);
   endtask

   task automatic t_mod_race();
      logic [7:0] v;
      prep(8'h05, 8'h80, 8'hFE);
      run(8);
      step_wr(2'd2, 8'h33);
      chk("R8 irq with mod write", int'(irq_w), 1);
      rd(2'd1, v); chk("R8 new mod loaded", v, 8'h33);
      rd(2'd2, v); chk("R8 mod register", v, 8'h33);
   endtask

   task automatic t_cancel();
      logic [7:0] v;
      prep(8'h05, 8'h80, 8'hFE);
      run(8);
      wr(2'd1, 8'h55);
      run(1);
      chk("R9 irq cancelled", irq_cnt, 0);
      rd(2'd1, v); chk("R9 written value kept", v, 8'h55);
   endtask

   task automatic t_done_ignore();
      logic [7:0] v;
      prep(8'h05, 8'h80, 8'hFE);
      run(9);
      wr(2'd1, 8'h11);
      rd(2'd1, v); chk("R10 write ignored after reload", v, 8'h80);
      run(1);
      wr(2'd1, 8'h11);
      rd(2'd1, v); chk("R10 write accepted later", v, 8'h11);
   endtask

   task automatic t_seq();
      logic [7:0] v;
      dbl_speed = 1'b0;
      prep(8'h00, 8'h00, 8'h00);
      run(2047);
      chk("R11 no tick before bit12 falls", seq_cnt, 0);
      run(1);
      chk("R11 tick on bit12 fall", seq_cnt, 1);
      run(1024);
      wr(2'd0, 8'h00);
      chk("R12 clear with bit12 set ticks", int'(seq_w), 1);
      wr(2'd0, 8'h00);
      chk("R12 clear with bit12 clear", int'(seq_w), 0);
      rd(2'd0, v); chk("R2 div cleared", v, 8'h00);
      dbl_speed = 1'b1;
      seq_cnt = 0;
      run(2048);
      chk("R11 double speed ignores bit12", seq_cnt, 0);
      run(2048);
      chk("R11 double speed tick bit13", seq_cnt, 1);
      dbl_speed = 1'b0;
   endtask

   task automatic t_ctl_read();
      logic [7:0] v;
      wr(2'd3, 8'hFF);
      rd(2'd3, v); chk("R13 ctl all ones", v, 8'hFF);
      wr(2'd3, 8'h05);
      rd(2'd3, v); chk("R13 ctl upper ones", v, 8'hFD);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_divider();
      t_periods();
      t_glitch();
      t_overflow();
      t_mod_race();
      t_cancel();
      t_done_ignore();
      t_seq();
      t_ctl_read();
      done = 1'b1;
      summary();
   end

endmodule